// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the slave input stage of a stereo audio path. A host supplies a bit clock, a frame sync that marks the left and right half-frames, and a serial data line. The block recovers one left and one right sample per frame and presents them on two parallel outputs. Each sample is a two's complement word sent MSB first. The word length is 16, 18 or 20 bits. The framing is I2S, MSB-justified or LSB-justified, and both are chosen by static select inputs.

The three pins are sampled on a system clock that runs several times faster than the bit clock and is synchronous to it. Each half-frame's bit count is measured. The outputs stay at zero and no strobe is issued until the framing has repeated consistently. Any disturbance in the framing puts the outputs back into that silent state.

Top module: `serial_audio_rx`

## Requirements
- R1: With `fmtSel` = 00 (I2S), frame sync low marks the left channel. The word MSB is taken on the bit-clock rising edge that follows the first rising edge at which the new frame-sync level is seen.
- R2: With `fmtSel` = 01 (MSB-justified), frame sync high marks the left channel. The MSB is taken on the first bit-clock rising edge at which the new frame-sync level is seen.
- R3: With `fmtSel` = 10 or 11 (LSB-justified), frame sync high marks the left channel. The word is the last N bits of the half-frame, taken before frame sync changes. Earlier bits in the half-frame have no effect.
- R4: `lenSel` sets the word length N: 00 gives 16 bits, 01 gives 18, and 10 or 11 gives 20. The word is left-aligned into the 20-bit output, with zeros below it. In I2S and MSB-justified modes, bits after the first N bits of a half-frame have no effect.
- R5: Serial data and frame sync are taken only at bit-clock rising edges. Their values between rising edges are ignored.
- R6: `locked` rises at the fourth consecutive half-frame end at which the ended half has both of these properties: it holds at least N bits, and its bit count equals that of the half before it.
- R7: A half-frame that breaks R6 drops `locked` and forces both outputs to zero. So do 127 bit-clock rising edges without a frame-sync change.
- R8: `sampleValid` pulses for exactly one cycle when a right half-frame ends while the block is locked, provided the left half of the same frame also matched. The pulse carries that frame's left and right words. It is visible two system clock edges after the bit-clock rise that ends the half. Between pulses the outputs hold their values.
- R9: While `rstN` is low, `locked` and `sampleValid` are low and both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, synchronous to and faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClk | input | 1 | Serial bit clock from the host |
| frameSync | input | 1 | Left/right frame sync from the host |
| serData | input | 1 | Serial audio data, MSB first |
| fmtSel | input | 2 | Framing select: 00 I2S, 01 MSB-justified, 1x LSB-justified |
| lenSel | input | 2 | Word length select: 00 16 bits, 01 18 bits, 1x 20 bits |
| leftOut | output | OUT_W (20) | Left sample, left-aligned |
| rightOut | output | OUT_W (20) | Right sample, left-aligned |
| sampleValid | output | 1 | One-cycle strobe marking a new sample pair |
| locked | output | 1 | Framing confirmed |

## Verification
Each bit-clock rise on the pins takes one clock edge to enter the input registers. The internal rise cycle follows, and the sample registers update on the next edge. A delivered pair is therefore due on the second clock edge after the host raises the bit clock, and the bench checks each strobe against that exact distance. `locked` and the output clearing follow the same two-edge path. For that reason the lock, timeout and reset checks sample only after the last bit of a scenario has been fully driven, and a few clocks later. Every expected pair is queued from the frame in which it is sent, and the queue must be empty at the end of each scenario.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  // Strobes sent from the framing control to the sample datapath, valid in one cycle
  typedef struct packed {
    logic sdBit;        // serial data bit taken at this bit-clock rise
    logic shiftEn;      // the bit belongs to the word window
    logic wordDone;     // a half-frame ended at this rise
    logic captureLeft;  // the ended half was a matching left half
    logic publish;      // deliver the pending left word and this right word
    logic clearOut;     // framing broke: silence the outputs
  } rxStrobe_t;

  localparam logic [1:0] FMT_I2S = 2'b00;

  function automatic logic [4:0] wordBits(input logic [1:0] lenCode);
    case (lenCode)
      2'b00:   return 5'd16;
      2'b01:   return 5'd18;
      default: return 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int LOCK_HALVES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       frameSync,
  input  logic       serData,
  input  logic [1:0] fmtSel,
  input  logic [1:0] lenSel,
  output rxStrobe_t  strobe,
  output logic       locked
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int MATCH_W = $clog2(LOCK_HALVES + 1);
  localparam logic [MATCH_W-1:0] LOCK_AT   = MATCH_W'(LOCK_HALVES - 1);
  localparam logic [MATCH_W-1:0] MATCH_TOP = MATCH_W'(LOCK_HALVES);

  logic clkQ, clkQ2, fsQ, sdQ;
  logic started, lrPrev, effPrev, havePrev, pendValid;
  logic [CNT_W-1:0] bitCnt, prevLen;
  logic [MATCH_W-1:0] matchCnt;

  logic rise, isI2s, isLsb, leftLevel, eff, boundary, good, endedLeft, timeout;
  logic [CNT_W-1:0] idx, wordLen;

  always_comb begin
    rise      = clkQ & ~clkQ2;
    isI2s     = (fmtSel == FMT_I2S);
    isLsb     = fmtSel[1];
    leftLevel = ~isI2s;
    // I2S frames are realigned by delaying frame sync one bit period
    eff       = isI2s ? lrPrev : fsQ;
    boundary  = rise && started && (eff != effPrev);
    idx       = boundary ? '0 : bitCnt;
    wordLen   = CNT_W'(wordBits(lenSel));
    good      = havePrev && (bitCnt == prevLen) && (bitCnt >= wordLen);
    endedLeft = (effPrev == leftLevel);
    timeout   = rise && started && !boundary && (bitCnt == CNT_MAX);

    strobe.sdBit       = sdQ;
    strobe.shiftEn     = rise && started && (isLsb || (idx < wordLen));
    strobe.wordDone    = boundary;
    strobe.captureLeft = boundary && good && endedLeft;
    strobe.publish     = boundary && good && !endedLeft && pendValid &&
                         (locked || (matchCnt == LOCK_AT));
    strobe.clearOut    = (boundary && !good) || timeout;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ <= 1'b0; clkQ2 <= 1'b0; fsQ <= 1'b0; sdQ <= 1'b0;
      started <= 1'b0; lrPrev <= 1'b0; effPrev <= 1'b0;
      havePrev <= 1'b0; pendValid <= 1'b0; locked <= 1'b0;
      bitCnt <= '0; prevLen <= '0; matchCnt <= '0;
    end else begin
      clkQ  <= bitClk;
      clkQ2 <= clkQ;
      fsQ   <= frameSync;
      sdQ   <= serData;
      if (rise) begin
        if (!started) begin
          started <= 1'b1;
          lrPrev  <= fsQ;
          effPrev <= fsQ;
          bitCnt  <= CNT_W'(1);
        end else begin
          lrPrev  <= fsQ;
          effPrev <= eff;
          if (boundary) begin
            bitCnt   <= CNT_W'(1);
            prevLen  <= bitCnt;
            havePrev <= 1'b1;
            if (good) begin
              if (matchCnt != MATCH_TOP) matchCnt <= matchCnt + 1'b1;
              if (matchCnt == LOCK_AT) locked <= 1'b1;
              pendValid <= endedLeft;
            end else begin
              matchCnt  <= '0;
              locked    <= 1'b0;
              pendValid <= 1'b0;
            end
          end else if (bitCnt == CNT_MAX) begin
            matchCnt  <= '0;
            locked    <= 1'b0;
            pendValid <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_dp.sv
module serial_audio_rx_dp
  import serial_audio_rx_pkg::*;
#(
  parameter int OUT_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       lenSel,
  input  rxStrobe_t        strobe,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             sampleValid
);
  logic [OUT_W-1:0] shiftReg, pendLeft, aligned;

  // Shifting by OUT_W-N drops stale bits above the word and zero-fills below it
  always_comb aligned = shiftReg << (OUT_W - int'(wordBits(lenSel)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      pendLeft    <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.publish;
      if (strobe.wordDone) begin
        if (strobe.captureLeft) pendLeft <= aligned;
        if (strobe.publish) begin
          leftOut  <= pendLeft;
          rightOut <= aligned;
        end
        shiftReg <= OUT_W'(strobe.sdBit);
      end else if (strobe.shiftEn) begin
        shiftReg <= {shiftReg[OUT_W-2:0], strobe.sdBit};
      end
      if (strobe.clearOut) begin
        leftOut  <= '0;
        rightOut <= '0;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int OUT_W       = 20,
  parameter int CNT_W       = 7,
  parameter int LOCK_HALVES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClk,
  input  logic             frameSync,
  input  logic             serData,
  input  logic [1:0]       fmtSel,
  input  logic [1:0]       lenSel,
  output logic [OUT_W-1:0] leftOut,
  output logic [OUT_W-1:0] rightOut,
  output logic             sampleValid,
  output logic             locked
);
  rxStrobe_t strobe;

  serial_audio_rx_ctrl #(.CNT_W(CNT_W), .LOCK_HALVES(LOCK_HALVES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .fmtSel(fmtSel), .lenSel(lenSel),
    .strobe(strobe), .locked(locked)
  );

  serial_audio_rx_dp #(.OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .lenSel(lenSel), .strobe(strobe),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int OUT_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       lenSel,
  input logic [OUT_W-1:0] leftOut,
  input logic [OUT_W-1:0] rightOut,
  input logic             sampleValid,
  input logic             locked
);
  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> locked); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R8

  AST_UNLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (leftOut == '0) && (rightOut == '0)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked) && !sampleValid) |-> ($stable(leftOut) && $stable(rightOut))); // R8

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && lenSel == 2'b00 && $past(lenSel) == 2'b00) |-> (rightOut[OUT_W-17:0] == '0)); // R4

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .lenSel(lenSel), .leftOut(leftOut),
  .rightOut(rightOut), .sampleValid(sampleValid), .locked(locked)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic bitClk = 1'b0, frameSync = 1'b0, serData = 1'b0;
  logic [1:0] fmtSel = 2'b00, lenSel = 2'b00;
  logic [19:0] leftOut, rightOut;
  logic sampleValid, locked;

  int vecCount = 0, failCount = 0;
  int cyc = 0, riseCyc = -100;
  logic [39:0] expQ[$];
  logic [39:0] expHead;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_audio_rx u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .serData(serData), .fmtSel(fmtSel), .lenSel(lenSel),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid),
    .locked(locked)
  );

  function automatic int nBits(input logic [1:0] l);
    return (l == 2'b00) ? 16 : (l == 2'b01) ? 18 : 20;
  endfunction

  function automatic logic [19:0] alignWord(input logic [19:0] w, input int n);
    return w << (20 - n);
  endfunction

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Monitor: each strobe must match the next queued pair, two edges after the bit clock rise
  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      check(cyc == riseCyc + 2, "R8 strobe timing", 40'(cyc - riseCyc), 40'd2);
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected strobe", {leftOut, rightOut}, 40'd0);
      end else begin
        expHead = expQ.pop_front();
        check({leftOut, rightOut} == expHead,
              (fmtSel == 2'b00) ? "R1 R4 R5 I2S pair" :
              (fmtSel == 2'b01) ? "R2 R4 R5 MSB-justified pair" : "R3 R4 R5 LSB-justified pair",
              {leftOut, rightOut}, expHead);
      end
    end
  end

  task automatic driveBit(input bit lr, input bit d);
    @(negedge clk);
    bitClk = 1'b0; frameSync = lr; serData = d;
    repeat (4) @(negedge clk);
    bitClk = 1'b1; riseCyc = cyc;
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset(input logic [1:0] f, input logic [1:0] l);
    @(negedge clk);
    rstN = 1'b0; fmtSel = f; lenSel = l; bitClk = 1'b0;
    repeat (3) @(negedge clk);
    check(!locked && !sampleValid && leftOut == 0 && rightOut == 0, "R9 reset state",
          {leftOut, rightOut}, 40'd0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Frames 0..frames-1 after a 3-bit preamble; pairs from frame 2 on are due (R6)
  task automatic sendStream(input logic [1:0] f, input logic [1:0] l, input int half,
                            input int frames, input int shortFrame, input bit expectLock);
    int n = nBits(l);
    bit isI2s = (f == 2'b00);
    bit bitsQ[$];
    bit labQ[$];
    logic [19:0] lw = '0, rw = '0, w;
    int hl;
    doReset(f, l);
    for (int k = 0; k < 3; k++) begin bitsQ.push_back(1'($urandom)); labQ.push_back(1'b0); end
    for (int fr = 0; fr < frames; fr++) begin
      for (int ch = 1; ch >= 0; ch--) begin
        hl = (fr == shortFrame && ch == 1) ? half - 2 : half;
        w = 20'($urandom) & 20'((1 << n) - 1);
        if (ch == 1) lw = w; else rw = w;
        if (hl < n) begin
          for (int k = 0; k < hl; k++) begin bitsQ.push_back(1'($urandom)); labQ.push_back(1'(ch)); end
        end else begin
          if (f[1]) for (int k = 0; k < hl - n; k++) begin bitsQ.push_back(1'($urandom)); labQ.push_back(1'(ch)); end
          for (int k = n - 1; k >= 0; k--) begin bitsQ.push_back(w[k]); labQ.push_back(1'(ch)); end
          if (!f[1]) for (int k = 0; k < hl - n; k++) begin bitsQ.push_back(1'($urandom)); labQ.push_back(1'(ch)); end
        end
      end
      if (fr >= 2 && (shortFrame < 0 || fr < shortFrame) && half >= n)
        expQ.push_back({alignWord(lw, n), alignWord(rw, n)});
    end
    for (int k = 0; k < 2; k++) begin bitsQ.push_back(1'($urandom)); labQ.push_back(1'b1); end
    for (int j = 0; j < bitsQ.size(); j++) begin
      bit lab = isI2s ? labQ[(j + 1 < labQ.size()) ? j + 1 : j] : labQ[j];
      driveBit(isI2s ? ~lab : lab, bitsQ[j]);
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 all due pairs delivered", 40'(expQ.size()), 40'd0);
    check(locked == expectLock, "R6 lock state after stream", 40'(locked), 40'(expectLock));
    expQ.delete();
  endtask

  initial begin
    int h;
    void'($urandom(32'h5A17));
    for (int f = 0; f < 4; f++) begin
      for (int l = 0; l < 3; l++) begin
        h = nBits(2'(l)) + ((l == 2) ? 0 : int'($urandom % 10));
        sendStream(2'(f), 2'(l), h, 6, -1, 1'b1);
      end
    end
    // R2: 20-bit MSB-justified at 40 bit clocks per frame
    sendStream(2'b01, 2'b10, 20, 7, -1, 1'b1);
    // R4: reserved length code 11 behaves as 20 bits
    sendStream(2'b01, 2'b11, 24, 6, -1, 1'b1);
    // R7: a short left half in frame 4 breaks lock
    sendStream(2'b01, 2'b00, 24, 6, 4, 1'b0);
    check(leftOut == 0 && rightOut == 0, "R7 outputs zero after deviation", {leftOut, rightOut}, 40'd0);
    // R6 R7: half-frames shorter than the word never lock
    sendStream(2'b10, 2'b10, 16, 6, -1, 1'b0);
    // R7: frame sync stalls with the bit clock running
    sendStream(2'b00, 2'b01, 24, 6, -1, 1'b1);
    for (int k = 0; k < 118; k++) driveBit(frameSync, 1'($urandom));
    repeat (3) @(negedge clk);
    check(locked == 1'b1, "R7 lock held below timeout", 40'(locked), 40'd1);
    for (int k = 0; k < 10; k++) driveBit(frameSync, 1'($urandom));
    repeat (3) @(negedge clk);
    check(locked == 1'b0 && leftOut == 0 && rightOut == 0, "R7 timeout unlock",
          {19'd0, locked, leftOut}, 40'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog R8 act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule